// File: doc/BRIEF.md
# External Switching-Clock Qualifier

This block decides whether a regulator's switching tick may be taken from an optional external system clock instead of the internal reference tick. It measures the external clock against the internal reference. It sorts the measured rate into one of three supported frequency bands and demands that the same band repeat over several measurement windows. Only after that does it hand the switching tick over to a divided copy of the external clock. The divider ratio follows from the band it found: 4 for the lowest band, 6 for the middle band and 8 for the highest. With these ratios the switching rate stays close to the internal rate.

The block runs on one core clock. The internal reference arrives as a single-cycle pulse in that domain. The external clock arrives as a raw level and passes through a synchronizer before its rising edges are counted. Three things make the block fall back to the internal reference at once: a measurement window that misses every band, a window that lands in a different band from the locked one, or a drop of the active mode's sync-enable bit. Its outputs are the switching tick, a locked flag and a code that gives the divider in use.

Top module: `extclk_qualifier`

## Requirements
- R1: While reset is asserted and after it is released, `sw_tick`, `locked` and `div_code` are 0 until a lock is earned.
- R2: While not locked, every `ref_tick` pulse appears on `sw_tick` exactly one core cycle later, and no other pulse appears there.
- R3: A measurement window begins at the first `ref_tick` after `sync_en` rises. It spans `WIN_TICKS` reference ticks and counts the synchronized rising edges of `ext_clk`. For each band the nominal count is `WIN_TICKS`×4, ×5.9 (floored) or ×8. The accepted range runs from floor(nominal×(100−3)/100) to floor(nominal×(100+3)/100), both ends included. Any other count is invalid.
- R4: `locked` rises only after four consecutive windows fall in the same band. `div_code` then reads 1 for the ×4 band, 2 for the ×5.9 band and 3 for the ×8 band, and it is 0 whenever the block is not locked.
- R5: Handover happens only at a switching-period boundary: in the cycle before `locked` rises, `sw_tick` carries the last internal tick.
- R6: While locked, `sw_tick` pulses once for every 4, 6 or 8 synchronized external rising edges (by band), and reference ticks no longer appear on it.
- R7: A window whose count is invalid clears `locked` and `div_code` in the cycle after the window closes, and `sw_tick` follows `ref_tick` again.
- R8: When `sync_en` is low, `locked` is 0 from the next cycle on, and measurement restarts from scratch when it rises again.
- R9: A valid window in a band other than the locked one clears `locked`, and a new lock then takes four consecutive windows of the new band.
- R10: `ext_clk` passes through a two-stage synchronizer, so a rising edge is counted three core cycles after the core clock first samples it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Internal reference switching pulse, one core cycle wide |
| ext_clk | input | 1 | Raw external system clock level |
| sync_en | input | 1 | Sync-enable bit of the active mode |
| sw_tick | output | 1 | Selected switching tick |
| locked | output | 1 | External clock qualified and in use |
| div_code | output | 2 | Divider in use: 0 none, 1 by 4, 2 by 6, 3 by 8 |

## Verification
On every cycle the assertions check these port relations. An unlocked tick is always an echoed reference pulse. A dropped enable clears the lock on the next cycle. The divider code is non-zero and steady while locked. A lock always starts right after an internal tick. Only the bench scenarios can show the rest, because it depends on many windows of history. That covers the band limits, the four-window lock count, the exact spacing of the divided ticks, and fallback on an invalid or foreign band followed by a fresh four-window relock. The bench also compares every output against a behavioural model that tracks the synchronizer latency of the external edges.

// File: rtl/extclk_qual_pkg.sv
package extclk_qual_pkg;
  typedef enum logic [1:0] {
    BAND_NONE = 2'd0,
    BAND_LO   = 2'd1,
    BAND_MID  = 2'd2,
    BAND_HI   = 2'd3
  } band_e;
endpackage

// File: rtl/extclk_edge_sync.sv
module extclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_lvl,
  output logic ext_rise
);
  logic [STAGES-1:0] sr_q, sr_d;
  logic              prev_q;

  always_comb begin
    sr_d[0] = ext_lvl;
    for (int i = 1; i < STAGES; i++) sr_d[i] = sr_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign ext_rise = sr_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/extclk_freq_meter.sv
module extclk_freq_meter
  import extclk_qual_pkg::*;
#(
  parameter int WIN_TICKS = 64,
  parameter int TOL_PCT   = 3,
  parameter int NOM_LO    = 256,
  parameter int NOM_MID   = 377,
  parameter int NOM_HI    = 512,
  parameter int CNT_W     = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sync_en,
  input  logic  ref_tick,
  input  logic  ext_rise,
  output logic  win_done,
  output band_e win_band
);
  localparam int WIN_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam int NOM [3] = '{NOM_LO, NOM_MID, NOM_HI};

  logic             armed_q, armed_d;
  logic [WIN_W-1:0] wcnt_q, wcnt_d;
  logic [CNT_W-1:0] ecnt_q, ecnt_d;
  logic             close;
  logic [2:0]       hit;
  band_e            band_d;

  for (genvar b = 0; b < 3; b++) begin : g_band
    localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(NOM[b] * (100 - TOL_PCT) / 100);
    localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(NOM[b] * (100 + TOL_PCT) / 100);
    assign hit[b] = (ecnt_q >= LIM_LO) && (ecnt_q <= LIM_HI);
  end

  always_comb begin
    if (hit[0])      band_d = BAND_LO;
    else if (hit[1]) band_d = BAND_MID;
    else if (hit[2]) band_d = BAND_HI;
    else             band_d = BAND_NONE;
  end

  assign close = sync_en & armed_q & ref_tick & (wcnt_q == WIN_LAST);

  always_comb begin
    armed_d = armed_q;
    wcnt_d  = wcnt_q;
    ecnt_d  = ecnt_q;
    if (!sync_en) begin
      armed_d = 1'b0;
      wcnt_d  = '0;
      ecnt_d  = '0;
    end else if (!armed_q) begin
      armed_d = ref_tick;
      wcnt_d  = '0;
      ecnt_d  = '0;
    end else if (close) begin
      wcnt_d  = '0;
      ecnt_d  = {{(CNT_W-1){1'b0}}, ext_rise};
    end else begin
      if (ref_tick) wcnt_d = wcnt_q + 1'b1;
      if (ext_rise && (ecnt_q != CNT_MAX)) ecnt_d = ecnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      wcnt_q   <= '0;
      ecnt_q   <= '0;
      win_done <= 1'b0;
      win_band <= BAND_NONE;
    end else begin
      armed_q  <= armed_d;
      wcnt_q   <= wcnt_d;
      ecnt_q   <= ecnt_d;
      win_done <= close;
      win_band <= band_d;
    end
  end
endmodule

// File: rtl/extclk_lock_ctrl.sv
module extclk_lock_ctrl
  import extclk_qual_pkg::*;
#(
  parameter int LOCK_WINS = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sync_en,
  input  logic  win_done,
  input  band_e win_band,
  output logic  locked,
  output band_e lock_band
);
  localparam int SW = $clog2(LOCK_WINS + 1);
  localparam logic [SW-1:0] STREAK_TOP = SW'(LOCK_WINS);

  logic [SW-1:0] streak_q, streak_d;
  band_e         last_q, last_d, lband_d;
  logic          locked_d;

  always_comb begin
    streak_d = streak_q;
    last_d   = last_q;
    locked_d = locked;
    lband_d  = lock_band;
    if (!sync_en) begin
      streak_d = '0;
      last_d   = BAND_NONE;
      locked_d = 1'b0;
      lband_d  = BAND_NONE;
    end else if (win_done) begin
      if (win_band == BAND_NONE) begin
        streak_d = '0;
        last_d   = BAND_NONE;
        locked_d = 1'b0;
        lband_d  = BAND_NONE;
      end else begin
        if (win_band == last_q)
          streak_d = (streak_q == STREAK_TOP) ? streak_q : streak_q + 1'b1;
        else
          streak_d = SW'(1);
        last_d = win_band;
        if (locked && (win_band != lock_band)) begin
          locked_d = 1'b0;
          lband_d  = BAND_NONE;
        end else if (!locked && (streak_d >= STREAK_TOP)) begin
          locked_d = 1'b1;
          lband_d  = win_band;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak_q  <= '0;
      last_q    <= BAND_NONE;
      locked    <= 1'b0;
      lock_band <= BAND_NONE;
    end else begin
      streak_q  <= streak_d;
      last_q    <= last_d;
      locked    <= locked_d;
      lock_band <= lband_d;
    end
  end
endmodule

// File: rtl/extclk_tick_mux.sv
module extclk_tick_mux
  import extclk_qual_pkg::*;
#(
  parameter int DIV_LO  = 4,
  parameter int DIV_MID = 6,
  parameter int DIV_HI  = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ref_tick,
  input  logic  ext_rise,
  input  logic  locked,
  input  band_e lock_band,
  output logic  sw_tick
);
  localparam int DMAX = (DIV_LO > DIV_MID) ? ((DIV_LO > DIV_HI) ? DIV_LO : DIV_HI)
                                           : ((DIV_MID > DIV_HI) ? DIV_MID : DIV_HI);
  localparam int DW = $clog2(DMAX);

  logic [DW-1:0] dcnt_q, dcnt_d, div_m1;
  logic          wrap, tick_d;

  always_comb begin
    unique case (lock_band)
      BAND_LO:  div_m1 = DW'(DIV_LO - 1);
      BAND_MID: div_m1 = DW'(DIV_MID - 1);
      default:  div_m1 = DW'(DIV_HI - 1);
    endcase
  end

  assign wrap = (dcnt_q == div_m1);

  always_comb begin
    dcnt_d = dcnt_q;
    if (!locked)       dcnt_d = '0;
    else if (ext_rise) dcnt_d = wrap ? '0 : dcnt_q + 1'b1;
    tick_d = locked ? (ext_rise & wrap) : ref_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q  <= '0;
      sw_tick <= 1'b0;
    end else begin
      dcnt_q  <= dcnt_d;
      sw_tick <= tick_d;
    end
  end
endmodule

// File: rtl/extclk_qualifier.sv
module extclk_qualifier
  import extclk_qual_pkg::*;
#(
  parameter int WIN_TICKS    = 64,
  parameter int TOL_PCT      = 3,
  parameter int LOCK_WINS    = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int RATIO_LO_X10 = 40,
  parameter int RATIO_MID_X10 = 59,
  parameter int RATIO_HI_X10 = 80,
  parameter int DIV_LO       = 4,
  parameter int DIV_MID      = 6,
  parameter int DIV_HI       = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       ext_clk,
  input  logic       sync_en,
  output logic       sw_tick,
  output logic       locked,
  output logic [1:0] div_code
);
  localparam int NOM_LO  = RATIO_LO_X10 * WIN_TICKS / 10;
  localparam int NOM_MID = RATIO_MID_X10 * WIN_TICKS / 10;
  localparam int NOM_HI  = RATIO_HI_X10 * WIN_TICKS / 10;
  localparam int CNT_W   = $clog2(2 * NOM_HI);

  logic  rst_q1, rst_core_n;
  logic  ext_rise, win_done;
  band_e win_band, lock_band;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_core_n <= rst_q1;
    end
  end

  extclk_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_core_n), .ext_lvl(ext_clk), .ext_rise(ext_rise)
  );

  extclk_freq_meter #(
    .WIN_TICKS(WIN_TICKS), .TOL_PCT(TOL_PCT), .NOM_LO(NOM_LO),
    .NOM_MID(NOM_MID), .NOM_HI(NOM_HI), .CNT_W(CNT_W)
  ) i_meter (
    .clk(clk), .rst_n(rst_core_n), .sync_en(sync_en), .ref_tick(ref_tick),
    .ext_rise(ext_rise), .win_done(win_done), .win_band(win_band)
  );

  extclk_lock_ctrl #(.LOCK_WINS(LOCK_WINS)) i_lock (
    .clk(clk), .rst_n(rst_core_n), .sync_en(sync_en), .win_done(win_done),
    .win_band(win_band), .locked(locked), .lock_band(lock_band)
  );

  extclk_tick_mux #(.DIV_LO(DIV_LO), .DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) i_mux (
    .clk(clk), .rst_n(rst_core_n), .ref_tick(ref_tick), .ext_rise(ext_rise),
    .locked(locked), .lock_band(lock_band), .sw_tick(sw_tick)
  );

  assign div_code = lock_band;
endmodule

// File: rtl/extclk_qualifier_chk.sv
module extclk_qualifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_tick,
  input logic       sync_en,
  input logic       sw_tick,
  input logic       locked,
  input logic [1:0] div_code
);
  // R2
  unlocked_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_tick && !$past(locked)) |-> $past(ref_tick));
  // R2
  ref_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && !locked) |=> sw_tick);
  // R4
  code_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (div_code != 2'd0));
  // R4
  code_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (div_code == 2'd0));
  // R6
  code_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(div_code));
  // R5
  boundary_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(sw_tick));
  // R8
  enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> !locked);
endmodule

bind extclk_qualifier extclk_qualifier_chk i_chk (
  .clk(clk), .rst_n(rst_core_n), .ref_tick(ref_tick), .sync_en(sync_en),
  .sw_tick(sw_tick), .locked(locked), .div_code(div_code)
);

// File: tb/test_extclk_qualifier.sv
module test_extclk_qualifier;
  localparam int WIN = 64;
  localparam int REF_PER = 48;
  localparam int LOCKN = 4;
  localparam int WIN_CYC = WIN * REF_PER;

  logic clk = 1'b0;
  logic rst_n, ref_tick, ext_clk, sync_en;
  logic sw_tick, locked;
  logic [1:0] div_code;

  always #4 clk = ~clk;

  extclk_qualifier i_extclk_qualifier (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ext_clk(ext_clk),
    .sync_en(sync_en), .sw_tick(sw_tick), .locked(locked), .div_code(div_code)
  );

  int errors = 0, checks = 0, cyc = 0;
  string cur_req = "R1";
  bit gen_on = 0;
  int ext_per = 0, ref_cnt = 0, ext_cnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // stimulus: drive inputs on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (gen_on) begin
      ref_tick <= (ref_cnt == REF_PER - 1);
      ref_cnt  <= (ref_cnt == REF_PER - 1) ? 0 : ref_cnt + 1;
    end else ref_tick <= 1'b0;
    if (ext_per > 0) begin
      if (ext_cnt >= ext_per / 2 - 1) begin
        ext_clk <= ~ext_clk;
        ext_cnt <= 0;
      end else ext_cnt <= ext_cnt + 1;
    end
  end

  // behavioural reference model, advanced on each rising edge
  int m_r1, m_r2, m_s0, m_s1, m_p, m_armed, m_w, m_e, m_done, m_band;
  int m_streak, m_last, m_lock, m_lband, m_d, m_sw;

  function automatic int band_of(input int c);
    int noms[3];
    noms = '{40 * WIN / 10, 59 * WIN / 10, 80 * WIN / 10};
    for (int b = 0; b < 3; b++)
      if (c >= noms[b] * 97 / 100 && c <= noms[b] * 103 / 100) return b + 1;
    return 0;
  endfunction

  task automatic model_clear();
    m_s0 = 0; m_s1 = 0; m_p = 0; m_armed = 0; m_w = 0; m_e = 0; m_done = 0;
    m_band = 0; m_streak = 0; m_last = 0; m_lock = 0; m_lband = 0; m_d = 0; m_sw = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; model_clear();
    end else begin
      if (!m_r2) model_clear();
      else begin
        int rise, close, dv, ns;
        rise  = m_s1 && !m_p;   // R10: two stages plus edge detect
        close = sync_en && m_armed && ref_tick && (m_w == WIN - 1);
        dv = (m_lband == 1) ? 4 : (m_lband == 2) ? 6 : 8;
        m_sw = m_lock ? (rise && m_d == dv - 1) : ref_tick;
        if (!m_lock) m_d = 0; else if (rise) m_d = (m_d == dv - 1) ? 0 : m_d + 1;
        if (!sync_en) begin
          m_streak = 0; m_last = 0; m_lock = 0; m_lband = 0;
        end else if (m_done) begin
          if (m_band == 0) begin
            m_streak = 0; m_last = 0; m_lock = 0; m_lband = 0;
          end else begin
            ns = (m_band == m_last) ? ((m_streak >= LOCKN) ? LOCKN : m_streak + 1) : 1;
            m_last = m_band;
            if (m_lock && m_band != m_lband) begin m_lock = 0; m_lband = 0; end
            else if (!m_lock && ns >= LOCKN) begin m_lock = 1; m_lband = m_band; end
            m_streak = ns;
          end
        end
        m_done = close;
        m_band = band_of(m_e);
        if (!sync_en) begin m_armed = 0; m_w = 0; m_e = 0; end
        else if (!m_armed) begin m_armed = ref_tick; m_w = 0; m_e = 0; end
        else if (close) begin m_w = 0; m_e = rise; end
        else begin
          if (ref_tick) m_w = m_w + 1;
          if (rise && m_e < 1023) m_e = m_e + 1;
        end
        m_p = m_s1; m_s1 = m_s0; m_s0 = ext_clk;
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    check(sw_tick == m_sw, {cur_req, " sw_tick vs model (R10 timing)"}, sw_tick, m_sw);
    check(locked == m_lock, {cur_req, " locked vs model"}, locked, m_lock);
    check(div_code == m_lband, {cur_req, " div_code vs model"}, div_code, m_lband);
  end

  // watchdog
  initial begin
    repeat (190000) @(negedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int prev_sw = 0;
  task automatic wait_lock(input int lim, output int took, output int sw_before);
    took = 0; sw_before = 0;
    while (!locked && took < lim) begin
      sw_before = sw_tick;
      @(negedge clk); took++;
    end
  endtask

  task automatic wait_unlock(input int lim, output int took);
    took = 0;
    while (locked && took < lim) begin @(negedge clk); took++; end
  endtask

  task automatic echo_check(input int n, input string req);
    int rcnt = 0, scnt = 0, last_rt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sw_tick) scnt++;
      if (last_rt) rcnt++;
      last_rt = ref_tick;
    end
    check(scnt == rcnt && rcnt > 0, req, scnt, rcnt);
  endtask

  initial begin
    int took, swb, gap;
    rst_n = 0; sync_en = 0; ref_tick = 0; ext_clk = 0;
    repeat (5) @(negedge clk);
    // R1 during reset
    check(sw_tick == 0, "R1 sw_tick in reset", sw_tick, 0);
    check(locked == 0, "R1 locked in reset", locked, 0);
    check(div_code == 0, "R1 div_code in reset", div_code, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    check(locked == 0 && div_code == 0, "R1 after release", locked, 0);

    gen_on = 1; ext_per = 12; cur_req = "R2";
    echo_check(600, "R2 ref echo while unsynced");

    sync_en = 1; cur_req = "R3";
    repeat (3 * WIN_CYC + 1500) @(negedge clk);
    check(locked == 0, "R3 no lock before four windows", locked, 0);
    cur_req = "R4";
    wait_lock(6000, took, swb);
    check(locked == 1, "R4 lock on x4 band", locked, 1);
    check(div_code == 1, "R4 div code x4", div_code, 1);
    check(swb == 1, "R5 handover after internal tick", swb, 1);

    cur_req = "R6";
    while (!sw_tick) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end while (!sw_tick);
      check(gap == 4 * 12, "R6 divide-by-4 spacing", gap, 48);
    end

    ext_per = 10; cur_req = "R7";
    wait_unlock(8000, took);
    check(locked == 0, "R7 invalid window drops lock", locked, 0);
    check(div_code == 0, "R7 div code cleared", div_code, 0);
    echo_check(300, "R7 ref ticks resume");

    ext_per = 6; cur_req = "R4";
    wait_lock(30000, took, swb);
    check(div_code == 3, "R4 div code x8", div_code, 3);
    check(swb == 1, "R5 handover boundary x8", swb, 1);

    ext_per = 8; cur_req = "R9";
    wait_unlock(8000, took);
    check(locked == 0, "R9 foreign band drops lock", locked, 0);
    repeat (3 * WIN_CYC - 300) @(negedge clk);
    check(locked == 0, "R9 no early relock", locked, 0);
    wait_lock(8000, took, swb);
    check(div_code == 2, "R9 relock on x5.9 band", div_code, 2);

    cur_req = "R8";
    sync_en = 0;
    @(negedge clk);
    check(locked == 0, "R8 enable drop clears lock", locked, 0);
    check(div_code == 0, "R8 div code cleared", div_code, 0);
    repeat (20) @(negedge clk);
    sync_en = 1;
    repeat (2 * WIN_CYC) @(negedge clk);
    check(locked == 0, "R8 measurement restarted", locked, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule